// File: doc/BRIEF.md
# External and Pin-Change Interrupt Unit

This block turns activity on interrupt pins into flagged, maskable requests for a CPU. It watches a set of dedicated interrupt pins. The default build uses pins 0, 1, 2, 3 and 6 of an 8-bit pin bus. For each of these pins a two-bit sense field selects low-level, falling-edge or rising-edge detection. It also watches a group of eight pin-change inputs. Each of those inputs can be masked on its own, and together they share one flag and one request.

Every pin passes through a two-flop synchronizer, and edges are found against a registered copy of the synchronized level. An edge event sets a flag whether or not its request is enabled. A flag is cleared in two ways: the CPU acknowledges the matching vector, or software writes a one to the flag bit. Requests toward the CPU are gated by a per-source enable and by a global interrupt enable input. Software reaches the unit through a small register port: a write strobe, an address and write data, with read data that is combinational from the address.

Top module: `extint_unit`

## Requirements
- R1: After reset every register reads zero, and `irq_ext` and `irq_pc` are low.
- R2: A dedicated source raises its `irq_ext` bit only when both its enable bit (address 0) and `global_ie` are one. The enable bit has no effect on whether the flag gets set.
- R3: Sense field value 2'b11 selects rising-edge detection. Sources 0 to 3 have their fields in address 2, source n at bits [2n+1:2n]. Source 6 has its field at bits [5:4] of address 3. A low-to-high change on the pin sets flag bit n at address 1 within three clock edges. This happens even when the source is disabled.
- R4: Sense field value 2'b10 selects falling-edge detection. A high-to-low change sets the flag, and a low-to-high change does not.
- R5: A flag is cleared by a one-cycle acknowledge: `ack_ext` bit n for a dedicated source, or `ack_pc` for the group. It is also cleared by writing a one to its bit, at address 1 for dedicated flags or bit 0 of address 5 for the group flag. Writing a zero to a flag bit leaves it unchanged.
- R6: Sense field values 2'b00 and 2'b01 select level mode. In level mode the flag reads zero at all times, and the request is active while the synchronized pin is low, the source is enabled and `global_ie` is one.
- R7: Bits for unused sources (4, 5, 7) in the enable, flag and sense registers read as zero, whatever value is written to them. Likewise, bits 7:1 of address 4 and of address 5 read as zero, and address 7 reads zero.
- R8: A change in either direction on a pin-change input whose bit is set in the mask at address 6 sets the group flag (bit 0 of address 5). A change on a masked-off input does not set it.
- R9: `irq_pc` is high exactly when the group flag, the group enable (bit 0 of address 4) and `global_ie` are all one.
- R10: If a flag's setting event and its clear (acknowledge or write-one) arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 8 | Dedicated interrupt pins (only enabled source positions are used) |
| pc_pin | input | 8 | Pin-change group inputs |
| global_ie | input | 1 | Global interrupt enable from the CPU |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ack_ext | input | 8 | Per-source vector acknowledge |
| ack_pc | input | 1 | Pin-change vector acknowledge |
| irq_ext | output | 8 | Per-source interrupt requests |
| irq_pc | output | 1 | Pin-change interrupt request |

## Verification
A flag that is stuck, set by the wrong edge, or missing after a set-and-clear collision is visible in the read data at address 1 or 5. It shows up on the third clock edge after the pin moves, so every check waits out that exact synchronizer and edge latency before sampling. A wrong enable or level-mode decision shows up on `irq_ext` or `irq_pc` in the same cycle that the register or `global_ie` changes, or two edges after a level pin moves. Decode faults that leak writes into unused or reserved bits appear immediately on read-back.

// File: rtl/extint_unit.sv
module extint_unit #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int PCW = 8,
  parameter int SYNC = 2,
  parameter logic [DW-1:0] SRC_MASK = 8'h4F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ext_pin,
  input  logic [PCW-1:0] pc_pin,
  input  logic          global_ie,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] ack_ext,
  input  logic          ack_pc,
  output logic [DW-1:0] irq_ext,
  output logic          irq_pc
);
  localparam int HALF = DW / 2;
  localparam logic [AW-1:0] A_EN = 0, A_FLG = 1, A_SNA = 2, A_SNB = 3,
                            A_GEN = 4, A_GFLG = 5, A_GMSK = 6;

  function automatic logic [DW-1:0] fld_mask(input int base);
    logic [DW-1:0] m;
    m = '0;
    for (int j = 0; j < HALF; j++)
      if (SRC_MASK[base + j]) m[2*j +: 2] = 2'b11;
    return m;
  endfunction

  localparam logic [DW-1:0] SNA_MASK = fld_mask(0);
  localparam logic [DW-1:0] SNB_MASK = fld_mask(HALF);

  logic [DW-1:0]  ext_s [SYNC];
  logic [PCW-1:0] pc_s  [SYNC];
  logic [DW-1:0]  ext_prev, src_en, src_flg, sense_a, sense_b;
  logic [PCW-1:0] pc_prev, grp_mask;
  logic           grp_en, grp_flg;

  logic [DW-1:0]  ext_now, rise, fall, set_src, lvl_mask, clr_src;
  logic [PCW-1:0] pc_now;
  logic           pc_hit, clr_grp;

  assign ext_now = ext_s[SYNC-1];
  assign pc_now  = pc_s[SYNC-1];
  assign rise    = ext_now & ~ext_prev;
  assign fall    = ~ext_now & ext_prev;
  assign pc_hit  = |((pc_now ^ pc_prev) & grp_mask);

  for (genvar i = 0; i < DW; i++) begin : g_src
    logic [1:0] md;
    if (i < HALF) begin : g_a
      assign md = sense_a[2*i +: 2];
    end else begin : g_b
      assign md = sense_b[2*(i-HALF) +: 2];
    end
    assign lvl_mask[i] = SRC_MASK[i] & ~md[1];
    assign set_src[i]  = SRC_MASK[i] & md[1] & (md[0] ? rise[i] : fall[i]);
    assign irq_ext[i]  = src_en[i] & global_ie &
                         (lvl_mask[i] ? ~ext_now[i] : src_flg[i]);
  end

  assign clr_src = ack_ext | ((reg_wr && reg_addr == A_FLG) ? reg_wdata : '0);
  assign clr_grp = ack_pc | (reg_wr && reg_addr == A_GFLG && reg_wdata[0]);
  assign irq_pc  = grp_flg & grp_en & global_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC; k++) begin
        ext_s[k] <= '0;
        pc_s[k]  <= '0;
      end
      ext_prev <= '0;
      pc_prev  <= '0;
      src_en   <= '0;
      src_flg  <= '0;
      sense_a  <= '0;
      sense_b  <= '0;
      grp_mask <= '0;
      grp_en   <= 1'b0;
      grp_flg  <= 1'b0;
    end else begin
      ext_s[0] <= ext_pin;
      pc_s[0]  <= pc_pin;
      for (int k = 1; k < SYNC; k++) begin
        ext_s[k] <= ext_s[k-1];
        pc_s[k]  <= pc_s[k-1];
      end
      ext_prev <= ext_now;
      pc_prev  <= pc_now;
      if (reg_wr) begin
        case (reg_addr)
          A_EN:   src_en   <= reg_wdata & SRC_MASK;
          A_SNA:  sense_a  <= reg_wdata & SNA_MASK;
          A_SNB:  sense_b  <= reg_wdata & SNB_MASK;
          A_GEN:  grp_en   <= reg_wdata[0];
          A_GMSK: grp_mask <= reg_wdata[PCW-1:0];
          default: ;
        endcase
      end
      src_flg <= ((src_flg & ~clr_src) | set_src) & ~lvl_mask & SRC_MASK;
      grp_flg <= (grp_flg & ~clr_grp) | pc_hit;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN:   reg_rdata = src_en;
      A_FLG:  reg_rdata = src_flg & ~lvl_mask;
      A_SNA:  reg_rdata = sense_a;
      A_SNB:  reg_rdata = sense_b;
      A_GEN:  reg_rdata[0] = grp_en;
      A_GFLG: reg_rdata[0] = grp_flg;
      A_GMSK: reg_rdata[PCW-1:0] = grp_mask;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module extint_unit_chk #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter logic [DW-1:0] SRC_MASK = 8'h4F
) (
  input logic          clk,
  input logic          rst_n,
  input logic          global_ie,
  input logic          ack_pc,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_rdata,
  input logic [DW-1:0] irq_ext,
  input logic          irq_pc,
  input logic [DW-1:0] src_en,
  input logic [DW-1:0] src_flg,
  input logic [DW-1:0] lvl_mask,
  input logic [DW-1:0] set_src,
  input logic          grp_flg,
  input logic          pc_hit
);
  p_gie_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !global_ie |-> (irq_ext == '0 && !irq_pc));

  p_en_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ext & ~src_en) == '0);

  p_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_ext | src_flg | src_en) & ~SRC_MASK) == '0);

  p_level_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(1)) |-> ((reg_rdata & lvl_mask) == '0));

  p_edge_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ext & ~lvl_mask & ~src_flg) == '0);

  p_grp_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hit |=> grp_flg);

  p_grp_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pc && !pc_hit) |=> !grp_flg);

  p_grp_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pc |-> grp_flg);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_src != '0) |=> ((src_flg & $past(set_src)) == $past(set_src)));
endmodule

bind extint_unit extint_unit_chk #(.DW(DW), .AW(AW), .SRC_MASK(SRC_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .global_ie(global_ie), .ack_pc(ack_pc),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq_ext(irq_ext), .irq_pc(irq_pc),
  .src_en(src_en), .src_flg(src_flg), .lvl_mask(lvl_mask), .set_src(set_src),
  .grp_flg(grp_flg), .pc_hit(pc_hit)
);

// File: tb/extint_unit_test.sv
module extint_unit_test;
  logic       clk = 0, rst_n = 0;
  logic [7:0] ext_pin = 0, pc_pin = 0, reg_wdata = 0, ack_ext = 0;
  logic       global_ie = 0, reg_wr = 0, ack_pc = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_rdata, irq_ext;
  logic       irq_pc;

  extint_unit uut (.clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .pc_pin(pc_pin),
    .global_ie(global_ie), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack_ext(ack_ext), .ack_pc(ack_pc), .irq_ext(irq_ext),
    .irq_pc(irq_pc));

  always #5 clk = ~clk;

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  event  smp;
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;

  always begin
    @(smp);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? reg_rdata : (it.kind == 1) ? irq_ext : {7'd0, irq_pc};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic want(input int kind, input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    if (kind == 0) reg_addr = a;
    #1;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    ->smp;
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic ack_e(input logic [7:0] m);
    @(negedge clk); ack_ext = m;
    @(negedge clk); ack_ext = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) want(0, a[2:0], 8'h00, "R1 reset register");
    want(1, 0, 8'h00, "R1 reset irq_ext");
    want(2, 0, 8'h00, "R1 reset irq_pc");

    wr(2, 8'hFF);
    wr(3, 8'hFF);
    wr(0, 8'hFF);
    want(0, 3, 8'h30, "R7 sense B unused fields");
    want(0, 0, 8'h4F, "R7 enable unused bits");
    wr(4, 8'hFF);
    want(0, 4, 8'h01, "R7 group enable reserved bits");
    wr(4, 8'h00);
    wr(7, 8'hFF);
    want(0, 7, 8'h00, "R7 address 7");

    @(negedge clk); ext_pin[0] = 1; settle();
    want(0, 1, 8'h01, "R3 rising edge sets flag");
    want(1, 0, 8'h00, "R2 no request without global enable");
    global_ie = 1; want(1, 0, 8'h01, "R2 request with enable and global");
    wr(0, 8'h00);
    want(1, 0, 8'h00, "R2 request needs enable bit");
    want(0, 1, 8'h01, "R2 flag kept while disabled");
    wr(0, 8'h4F);
    wr(1, 8'h00);
    want(0, 1, 8'h01, "R5 writing zero keeps flag");
    wr(1, 8'h01);
    want(0, 1, 8'h00, "R5 write one clears flag");

    wr(2, 8'hFB);
    @(negedge clk); ext_pin[1] = 1; settle();
    want(0, 1, 8'h00, "R4 rising ignored in falling mode");
    ext_pin[1] = 0; settle();
    want(0, 1, 8'h02, "R4 falling edge sets flag");
    want(1, 0, 8'h02, "R4 falling request");
    ack_e(8'h02);
    want(0, 1, 8'h00, "R5 acknowledge clears flag");
    want(1, 0, 8'h00, "R5 request drops after acknowledge");

    wr(0, 8'h00);
    ext_pin[6] = 1; settle();
    want(0, 1, 8'h40, "R3 source 6 rising sets flag while disabled");
    wr(0, 8'h4F);
    want(1, 0, 8'h40, "R3 source 6 request");
    ack_e(8'h40);
    want(0, 1, 8'h00, "R5 source 6 acknowledge");

    wr(2, 8'hCB);
    settle();
    want(1, 0, 8'h04, "R6 low level requests");
    want(0, 1, 8'h00, "R6 level flag reads zero");
    ext_pin[2] = 1; settle();
    want(1, 0, 8'h00, "R6 high level no request");
    want(0, 1, 8'h00, "R6 flag zero after level change");
    ext_pin[2] = 0; settle();
    want(1, 0, 8'h04, "R6 request follows level");
    global_ie = 0; want(1, 0, 8'h00, "R6 level gated by global enable");
    global_ie = 1;
    wr(0, 8'h4B);

    @(negedge clk); ext_pin[3] = 1;
    @(negedge clk); @(negedge clk);
    ack_ext = 8'h08;
    @(negedge clk); ack_ext = 0;
    want(0, 1, 8'h08, "R10 set beats acknowledge");
    wr(1, 8'h08);
    want(0, 1, 8'h00, "R5 clear after collision");

    wr(6, 8'h05);
    wr(4, 8'h01);
    pc_pin[1] = 1; settle();
    want(0, 5, 8'h00, "R8 masked input ignored");
    want(2, 0, 8'h00, "R8 no group request from masked input");
    pc_pin[2] = 1; settle();
    want(0, 5, 8'h01, "R8 rising change sets group flag");
    want(2, 0, 8'h01, "R9 group request");
    @(negedge clk); ack_pc = 1; @(negedge clk); ack_pc = 0;
    want(0, 5, 8'h00, "R5 group acknowledge");
    pc_pin[2] = 0; settle();
    want(0, 5, 8'h01, "R8 falling change sets group flag");
    wr(5, 8'h00);
    want(0, 5, 8'h01, "R5 group write zero keeps flag");
    wr(4, 8'h00);
    want(2, 0, 8'h00, "R9 group enable gates request");
    wr(4, 8'h01);
    global_ie = 0; want(2, 0, 8'h00, "R9 global gates group request");
    global_ie = 1; want(2, 0, 8'h01, "R9 group request restored");
    wr(5, 8'h01);
    want(0, 5, 8'h00, "R5 group write one clears");

    @(negedge clk); pc_pin[0] = 1;
    @(negedge clk); @(negedge clk);
    ack_pc = 1;
    @(negedge clk); ack_pc = 0;
    want(0, 5, 8'h01, "R10 group set beats acknowledge");

    #3;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule